// File: doc/BRIEF.md
# Event Fragment Packer with Link Flow Control

The packer gathers hit records from up to sixteen front-end inputs for each trigger and sends them as one framed event on a 32-bit link that is synchronous to the block clock. A frame is a header word, then the stored hit words in arrival order, then a trailer word. Beside the data word the block drives a word-valid strobe, a header strobe, a trailer strobe and a half-event strobe. The half-event strobe lets the receiver split an event between the lower inputs (0-7) and the upper inputs (8-15).

Trigger information (trigger type, data type, event number) goes into a two-entry trigger queue. Hits for the oldest unclosed trigger go into a hit buffer. A fragment-end pulse closes that trigger's fragment. A frame starts only when a trigger is queued and its fragment is closed.

The receiver raises a nearly-full line. The block then limits how many more words it sends and holds until the line drops. A busy output warns the trigger side when the trigger queue or the hit buffer is full. Hits that arrive while the buffer is full are discarded. The trailer of that event is still sent, and it carries an overflow quality code.

Top module: `evpk_packer`

## Requirements
- R1: A header word has bit 31 = 1, bits 30-27 = trigger type, bit 26 = 0, bits 25-23 = data type, bits 22-8 = 0 and bits 7-0 = event number. On that word `link_hdr` and `link_den` are both 1. `link_hdr` is 1 on no other word.
- R2: A hit word has bits 31-23 = 0, bits 22-20 = time block, bits 19-16 = input number, bits 15-9 = strip position and bits 8-0 = pulse height. On a hit word `link_den` = 1 and `link_hdr` = `link_trl` = 0.
- R3: A trailer word has bit 31 = 0, bits 30-29 = quality (00 normal, 11 overflow), bits 28-20 = 0, bits 19-8 = number of hit words in the frame and bits 7-0 = event number. On that word `link_trl` and `link_den` are both 1. `link_trl` is 1 on no other word.
- R4: Once `rx_afull` has been sampled high on a clock edge, at most 4 words are sent on that edge and the following edges while it stays high. Sending resumes after it is released.
- R5: `link_half` is 1 on the first hit word of a frame whose input number is 8 or more. It is 1 at most once per frame and never on a header or trailer.
- R6: A hit record with time block 0 marks "no hit data". It is not stored, not sent and not counted in the trailer.
- R7: A hit arriving while the hit buffer holds HIT_DEPTH records is dropped. The frame still ends with a trailer that has quality 11 and counts only the kept hits.
- R8: `busy` is 1 exactly while the trigger queue holds 2 entries or the hit buffer holds HIT_DEPTH records.
- R9: Up to 2 triggers are queued while a frame is pending. A trigger offered while the queue is full is ignored and produces no frame.
- R10: Frames leave in trigger order, and the hit words inside a frame keep their arrival order.
- R11: After reset all link strobes are 0 and `busy` is 0.
- R12: A hit presented in the same cycle as `frag_end` belongs to the fragment that pulse closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Trigger strobe |
| trig_type | input | 4 | Trigger type for the header |
| trig_dtype | input | 3 | Data type for the header |
| trig_evnum | input | 8 | Event number for header and trailer |
| hit_valid | input | 1 | Hit record strobe |
| hit_tblk | input | 3 | Time block (0 = no hit) |
| hit_input | input | 4 | Input channel number |
| hit_pos | input | 7 | Strip position |
| hit_ph | input | 9 | Pulse height |
| frag_end | input | 1 | Closes the oldest open fragment |
| rx_afull | input | 1 | Receiver nearly full |
| link_data | output | 32 | Link data word |
| link_den | output | 1 | Link word valid |
| link_hdr | output | 1 | Header word strobe |
| link_trl | output | 1 | Trailer word strobe |
| link_half | output | 1 | First upper-half hit word |
| busy | output | 1 | Buffers at their limit |

## Verification
Two pairs of functions can fall in the same cycle, and each is provoked on purpose.

The first pair is hit intake and fragment closing. The bench presents the last hit of a fragment together with `frag_end`, and expects that hit inside the frame that closes rather than in the next one.

The second pair is frame transmission and the nearly-full stop. The bench toggles `rx_afull` at random while frames of varying length are in flight, so that the line also rises on header and trailer words. It keeps its own count of the words sent under a held nearly-full and judges each one against the limit of four. It also compares every word and strobe with a frame model built from the stimulus.

// File: rtl/evpk_pkg.sv
package evpk_pkg;

  localparam int NUM_INPUTS = 16;
  localparam logic [1:0] QUAL_OK  = 2'b00;
  localparam logic [1:0] QUAL_OVF = 2'b11;

  typedef struct packed {
    logic [3:0] ttype;
    logic [2:0] dtype;
    logic [7:0] evnum;
  } trig_rec_t;

  typedef struct packed {
    logic [2:0] tblk;
    logic [3:0] inp;
    logic [6:0] pos;
    logic [8:0] ph;
  } hit_rec_t;

  function automatic logic [31:0] pk_header(input trig_rec_t t);
    logic [31:0] w;
    w = '0;
    w[31]    = 1'b1;
    w[30:27] = t.ttype;
    w[25:23] = t.dtype;
    w[7:0]   = t.evnum;
    return w;
  endfunction

  function automatic logic [31:0] pk_hit(input hit_rec_t h);
    logic [31:0] w;
    w = '0;
    w[22:20] = h.tblk;
    w[19:16] = h.inp;
    w[15:9]  = h.pos;
    w[8:0]   = h.ph;
    return w;
  endfunction

  function automatic logic [31:0] pk_trailer(input logic [1:0] qual,
                                             input logic [11:0] cnt,
                                             input logic [7:0] evnum);
    logic [31:0] w;
    w = '0;
    w[30:29] = qual;
    w[19:8]  = cnt;
    w[7:0]   = evnum;
    return w;
  endfunction

  function automatic logic upper_half(input logic [3:0] inp);
    return inp >= 4'(NUM_INPUTS / 2);
  endfunction

endpackage

// File: rtl/evpk_fifo.sv
module evpk_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign do_push = push && (count != CW'(DEPTH));
  assign do_pop  = pop && (count != '0);
  assign dout    = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= nxt_ptr(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  // R7 / R9: storage never grows past its depth
  a_r7_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

endmodule

// File: rtl/evpk_intake.sv
module evpk_intake
  import evpk_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_valid,
  input  hit_rec_t         hit_in,
  input  logic             frag_end,
  input  logic             hit_full,
  output logic             hit_push,
  output logic             close_push,
  output logic [CNT_W:0]   close_rec
);

  logic             real_hit;
  logic             dropped;
  logic [CNT_W-1:0] cur_cnt;
  logic             cur_drop;
  logic [CNT_W-1:0] sum_cnt;
  logic             sum_drop;

  // R6: a zero time block carries no hit data
  assign real_hit   = hit_valid && (hit_in.tblk != 3'd0);
  // R7: full buffer drops the record and marks the fragment
  assign hit_push   = real_hit && !hit_full;
  assign dropped    = real_hit && hit_full;
  // R12: a hit together with frag_end is folded into the closing fragment
  assign sum_cnt    = cur_cnt + CNT_W'(hit_push);
  assign sum_drop   = cur_drop | dropped;
  assign close_push = frag_end;
  assign close_rec  = {sum_drop, sum_cnt};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_cnt  <= '0;
      cur_drop <= 1'b0;
    end else if (frag_end) begin
      cur_cnt  <= '0;
      cur_drop <= 1'b0;
    end else begin
      cur_cnt  <= sum_cnt;
      cur_drop <= sum_drop;
    end
  end

endmodule

// File: rtl/evpk_sender.sv
module evpk_sender
  import evpk_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int AFULL_LAT = 2,
  parameter int MAX_AFTER = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_afull,
  input  logic             trig_avail,
  input  trig_rec_t        trig_rec,
  input  logic             close_avail,
  input  logic [CNT_W:0]   close_rec,
  input  hit_rec_t         hit_rec,
  output logic             pop_trig,
  output logic             pop_close,
  output logic             pop_hit,
  output logic [31:0]      link_data,
  output logic             link_den,
  output logic             link_hdr,
  output logic             link_trl,
  output logic             link_half
);

  typedef enum logic {S_IDLE, S_BODY} snd_state_t;

  snd_state_t       state, nxt_state;
  logic [CNT_W-1:0] remain, nxt_remain;
  logic [CNT_W-1:0] ev_cnt, nxt_ev_cnt;
  logic             ev_drop, nxt_ev_drop;
  logic [7:0]       ev_num, nxt_ev_num;
  logic             half_done, nxt_half_done;
  logic             stall;
  logic             emit;
  logic [31:0]      nxt_data;
  logic             nxt_hdr, nxt_trl, nxt_half;

  // nearly-full sampling chain; its length bounds the words sent after a rise
  generate
    if (AFULL_LAT <= 1) begin : g_af1
      logic af_q;
      always_ff @(posedge clk) begin
        if (!rst_n) af_q <= 1'b0;
        else        af_q <= rx_afull;
      end
      assign stall = af_q;
    end else begin : g_afn
      logic [AFULL_LAT-1:0] af_q;
      always_ff @(posedge clk) begin
        if (!rst_n) af_q <= '0;
        else        af_q <= {af_q[AFULL_LAT-2:0], rx_afull};
      end
      assign stall = af_q[AFULL_LAT-1];
    end
  endgenerate

  always_comb begin
    nxt_state     = state;
    nxt_remain    = remain;
    nxt_ev_cnt    = ev_cnt;
    nxt_ev_drop   = ev_drop;
    nxt_ev_num    = ev_num;
    nxt_half_done = half_done;
    emit          = 1'b0;
    nxt_data      = '0;
    nxt_hdr       = 1'b0;
    nxt_trl       = 1'b0;
    nxt_half      = 1'b0;
    pop_trig      = 1'b0;
    pop_close     = 1'b0;
    pop_hit       = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (trig_avail && close_avail && !stall) begin
          emit          = 1'b1;
          nxt_hdr       = 1'b1;
          nxt_data      = pk_header(trig_rec);
          pop_trig      = 1'b1;
          pop_close     = 1'b1;
          nxt_remain    = close_rec[CNT_W-1:0];
          nxt_ev_cnt    = close_rec[CNT_W-1:0];
          nxt_ev_drop   = close_rec[CNT_W];
          nxt_ev_num    = trig_rec.evnum;
          nxt_half_done = 1'b0;
          nxt_state     = S_BODY;
        end
      end
      S_BODY: begin
        if (!stall) begin
          emit = 1'b1;
          if (remain != '0) begin
            nxt_data      = pk_hit(hit_rec);
            pop_hit       = 1'b1;
            nxt_remain    = remain - 1'b1;
            nxt_half      = upper_half(hit_rec.inp) && !half_done;
            nxt_half_done = half_done | upper_half(hit_rec.inp);
          end else begin
            nxt_trl   = 1'b1;
            nxt_data  = pk_trailer(ev_drop ? QUAL_OVF : QUAL_OK,
                                   12'(ev_cnt), ev_num);
            nxt_state = S_IDLE;
          end
        end
      end
      default: nxt_state = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      remain    <= '0;
      ev_cnt    <= '0;
      ev_drop   <= 1'b0;
      ev_num    <= '0;
      half_done <= 1'b0;
      link_data <= '0;
      link_den  <= 1'b0;
      link_hdr  <= 1'b0;
      link_trl  <= 1'b0;
      link_half <= 1'b0;
    end else begin
      state     <= nxt_state;
      remain    <= nxt_remain;
      ev_cnt    <= nxt_ev_cnt;
      ev_drop   <= nxt_ev_drop;
      ev_num    <= nxt_ev_num;
      half_done <= nxt_half_done;
      link_data <= nxt_data;
      link_den  <= emit;
      link_hdr  <= nxt_hdr;
      link_trl  <= nxt_trl;
      link_half <= nxt_half;
    end
  end

  // words sent on edges where nearly-full is held high
  logic [2:0] since_af;
  always_ff @(posedge clk) begin
    if (!rst_n)        since_af <= '0;
    else if (!rx_afull) since_af <= '0;
    else if (emit && since_af != 3'd7) since_af <= since_af + 1'b1;
  end

  a_r4_afull_limit: assert property (@(posedge clk) disable iff (!rst_n)
    since_af <= 3'(MAX_AFTER));

  a_r1_hdr_trl_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(link_hdr && link_trl));

  a_r3_strobe_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (link_hdr || link_trl) |-> link_den);

  a_r5_half_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    link_half |-> (link_den && !link_hdr && !link_trl));

  a_r1_header_marker: assert property (@(posedge clk) disable iff (!rst_n)
    link_hdr |-> link_data[31]);

endmodule

// File: rtl/evpk_packer.sv
module evpk_packer
  import evpk_pkg::*;
#(
  parameter int HIT_DEPTH  = 16,
  parameter int TRIG_DEPTH = 2,
  parameter int CNT_W      = 12,
  parameter int AFULL_LAT  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trig_valid,
  input  logic [3:0]  trig_type,
  input  logic [2:0]  trig_dtype,
  input  logic [7:0]  trig_evnum,
  input  logic        hit_valid,
  input  logic [2:0]  hit_tblk,
  input  logic [3:0]  hit_input,
  input  logic [6:0]  hit_pos,
  input  logic [8:0]  hit_ph,
  input  logic        frag_end,
  input  logic        rx_afull,
  output logic [31:0] link_data,
  output logic        link_den,
  output logic        link_hdr,
  output logic        link_trl,
  output logic        link_half,
  output logic        busy
);

  localparam int TW  = $bits(trig_rec_t);
  localparam int HW  = $bits(hit_rec_t);
  localparam int CLW = CNT_W + 1;
  localparam int TCW = $clog2(TRIG_DEPTH + 1);
  localparam int HCW = $clog2(HIT_DEPTH + 1);

  trig_rec_t        trig_in, trig_head;
  hit_rec_t         hit_in, hit_head;
  logic [TW-1:0]    trig_dout;
  logic [HW-1:0]    hit_dout;
  logic [CLW-1:0]   close_din, close_dout;
  logic [TCW-1:0]   trig_count, close_count;
  logic [HCW-1:0]   hit_count;
  logic             trig_full, hit_full;
  logic             hit_push, close_push;
  logic             pop_trig, pop_close, pop_hit;

  assign trig_in   = '{ttype: trig_type, dtype: trig_dtype, evnum: trig_evnum};
  assign hit_in    = '{tblk: hit_tblk, inp: hit_input, pos: hit_pos, ph: hit_ph};
  assign trig_head = trig_rec_t'(trig_dout);
  assign hit_head  = hit_rec_t'(hit_dout);
  assign trig_full = (trig_count == TCW'(TRIG_DEPTH));
  assign hit_full  = (hit_count == HCW'(HIT_DEPTH));
  assign busy      = trig_full || hit_full;

  evpk_fifo #(.W(TW), .DEPTH(TRIG_DEPTH)) u_trig_q (
    .clk(clk), .rst_n(rst_n), .push(trig_valid), .din(TW'(trig_in)),
    .pop(pop_trig), .dout(trig_dout), .count(trig_count));

  evpk_fifo #(.W(CLW), .DEPTH(TRIG_DEPTH)) u_close_q (
    .clk(clk), .rst_n(rst_n), .push(close_push), .din(close_din),
    .pop(pop_close), .dout(close_dout), .count(close_count));

  evpk_fifo #(.W(HW), .DEPTH(HIT_DEPTH)) u_hit_q (
    .clk(clk), .rst_n(rst_n), .push(hit_push), .din(HW'(hit_in)),
    .pop(pop_hit), .dout(hit_dout), .count(hit_count));

  evpk_intake #(.CNT_W(CNT_W)) u_intake (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_in(hit_in),
    .frag_end(frag_end), .hit_full(hit_full), .hit_push(hit_push),
    .close_push(close_push), .close_rec(close_din));

  evpk_sender #(.CNT_W(CNT_W), .AFULL_LAT(AFULL_LAT)) u_sender (
    .clk(clk), .rst_n(rst_n), .rx_afull(rx_afull),
    .trig_avail(trig_count != '0), .trig_rec(trig_head),
    .close_avail(close_count != '0), .close_rec(close_dout),
    .hit_rec(hit_head), .pop_trig(pop_trig), .pop_close(pop_close),
    .pop_hit(pop_hit), .link_data(link_data), .link_den(link_den),
    .link_hdr(link_hdr), .link_trl(link_trl), .link_half(link_half));

  // R8: while busy from a full trigger queue, an offered trigger leaves it full
  a_r8_trig_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_full && !pop_trig) |=> trig_full);

  // R9: a pop that does not coincide with a push shrinks the queue
  a_r9_trig_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_trig && !trig_valid) |=> (trig_count == $past(trig_count) - 1'b1));

endmodule

// File: tb/evpk_packer_tb.sv
module evpk_packer_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        trig_valid;
  logic [3:0]  trig_type;
  logic [2:0]  trig_dtype;
  logic [7:0]  trig_evnum;
  logic        hit_valid;
  logic [2:0]  hit_tblk;
  logic [3:0]  hit_input;
  logic [6:0]  hit_pos;
  logic [8:0]  hit_ph;
  logic        frag_end;
  logic        rx_afull;
  logic [31:0] link_data;
  logic        link_den, link_hdr, link_trl, link_half, busy;

  always #5 clk = ~clk;

  evpk_packer u_dut (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_type(trig_type),
    .trig_dtype(trig_dtype), .trig_evnum(trig_evnum), .hit_valid(hit_valid),
    .hit_tblk(hit_tblk), .hit_input(hit_input), .hit_pos(hit_pos),
    .hit_ph(hit_ph), .frag_end(frag_end), .rx_afull(rx_afull),
    .link_data(link_data), .link_den(link_den), .link_hdr(link_hdr),
    .link_trl(link_trl), .link_half(link_half), .busy(busy));

  typedef struct {
    logic [31:0] d;
    bit          h, t, hf;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  int   af_mode = 0;
  int   af_run = 0;
  int   cycles = 0;
  bit   done = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor, nearly-full driver and watchdog share one negedge process
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
    if (rst_n && link_den) begin
      if (exp_q.size() == 0) begin
        check(0, "R9", "unexpected word", link_data, 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(link_data == e.d, e.tag, "data (R10 order)", link_data, e.d);
        check(link_hdr == e.h && link_trl == e.t, e.tag, "hdr/trl strobes",
              {link_hdr, link_trl}, {e.h, e.t});
        check(link_half == e.hf, "R5", "half strobe", link_half, e.hf);
      end
    end
    // R4: count words sent on edges where nearly-full was sampled high
    if (rx_afull) begin
      if (link_den) begin
        af_run++;
        check(af_run <= 4, "R4", "words after nearly-full", af_run, 4);
      end
    end else af_run = 0;
    if (af_mode == 0) rx_afull = 1'b0;
    else if (af_mode == 2) rx_afull = 1'b1;
    else if ($urandom % 4 == 0) rx_afull = ~rx_afull;
  end

  task automatic pulse_trig(input [3:0] tt, input [2:0] dt, input [7:0] ev);
    trig_valid = 1; trig_type = tt; trig_dtype = dt; trig_evnum = ev;
    @(negedge clk);
    trig_valid = 0;
  endtask

  // drives one fragment and queues the expected frame
  task automatic send_frag(input [3:0] tt, input [2:0] dt, input [7:0] ev,
                           input int nh, input bit zeros, input bit end_with,
                           input int keep_lim, input string tag);
    exp_t e;
    int   kept = 0;
    bit   drop = 0;
    bit   half_seen = 0;
    e.d = {1'b1, tt, 1'b0, dt, 15'd0, ev}; e.h = 1; e.t = 0; e.hf = 0; e.tag = tag;
    exp_q.push_back(e);
    for (int i = 0; i < nh; i++) begin
      logic [2:0] tb;
      logic [3:0] in;
      logic [6:0] ps;
      logic [8:0] ph;
      tb = zeros ? 3'($urandom % 8) : 3'(1 + $urandom % 7);
      in = 4'($urandom); ps = 7'($urandom); ph = 9'($urandom);
      hit_valid = 1; hit_tblk = tb; hit_input = in; hit_pos = ps; hit_ph = ph;
      frag_end = end_with && (i == nh - 1);
      if (tb != 0) begin      // R6: zero time block never appears
        if (kept < keep_lim) begin
          kept++;
          e.d = {9'd0, tb, in, ps, ph}; e.h = 0; e.t = 0;
          e.hf = (in >= 8) && !half_seen;
          half_seen = half_seen || (in >= 8);
          e.tag = (frag_end) ? "R12" : (zeros ? "R6" : "R2");
          exp_q.push_back(e);
        end else drop = 1;    // R7
      end
      @(negedge clk);
    end
    hit_valid = 0;
    if (!end_with || nh == 0) begin
      frag_end = 1;
      @(negedge clk);
    end
    frag_end = 0;
    e.d = {1'b0, drop ? 2'b11 : 2'b00, 9'd0, 12'(kept), ev};
    e.h = 0; e.t = 1; e.hf = 0; e.tag = drop ? "R7" : "R3";
    exp_q.push_back(e);
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; trig_valid = 0; trig_type = 0; trig_dtype = 0; trig_evnum = 0;
    hit_valid = 0; hit_tblk = 0; hit_input = 0; hit_pos = 0; hit_ph = 0;
    frag_end = 0; rx_afull = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11: reset state
    check({link_den, link_hdr, link_trl, link_half} == 4'b0, "R11", "strobes",
          {link_den, link_hdr, link_trl, link_half}, 0);
    check(busy == 0, "R11", "busy", busy, 0);

    // plain frames, empty fragment, all-upper/lower patterns
    pulse_trig(4'h3, 3'd5, 8'h11);
    send_frag(4'h3, 3'd5, 8'h11, 6, 0, 0, 1000, "R1");
    wait_drain();
    pulse_trig(4'hF, 3'd7, 8'hFE);
    send_frag(4'hF, 3'd7, 8'hFE, 0, 0, 0, 1000, "R1");
    wait_drain();
    check(busy == 0, "R8", "busy idle", busy, 0);

    // sweep under random nearly-full: R4, R5, R6, R10, R12
    af_mode = 1;
    for (int ev = 0; ev < 48; ev++) begin
      logic [3:0] tt;
      logic [2:0] dt;
      tt = 4'($urandom); dt = 3'($urandom);
      pulse_trig(tt, dt, 8'(ev + 32));
      send_frag(tt, dt, 8'(ev + 32), ev % 17, (ev % 3) == 0, ev[0], 1000, "R1");
      wait_drain();
    end
    af_mode = 0;
    wait_drain();

    // R7 and R8: overflow with the link held off
    af_mode = 2;
    repeat (4) @(negedge clk);
    pulse_trig(4'h5, 3'd2, 8'h77);
    send_frag(4'h5, 3'd2, 8'h77, 20, 0, 0, 16, "R1");
    check(busy == 1, "R8", "busy on full hit buffer", busy, 1);
    af_mode = 0;
    wait_drain();
    check(busy == 0, "R8", "busy after drain", busy, 0);

    // R9: two triggers queue, a third is ignored
    af_mode = 2;
    repeat (4) @(negedge clk);
    pulse_trig(4'h1, 3'd1, 8'hA1);
    pulse_trig(4'h2, 3'd2, 8'hA2);
    check(busy == 1, "R8", "busy on full trigger queue", busy, 1);
    pulse_trig(4'h3, 3'd3, 8'hA3);
    send_frag(4'h1, 3'd1, 8'hA1, 4, 0, 0, 1000, "R9");
    send_frag(4'h2, 3'd2, 8'hA2, 3, 0, 1, 1000, "R9");
    af_mode = 0;
    wait_drain();
    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R9", "queue empty", exp_q.size(), 0);
    check(busy == 0, "R8", "busy final", busy, 0);

    done = 1;
    finish_run();
  end

endmodule